// File: doc/BRIEF.md
# In-Order Memory Access Sequencer with Prefetch

This block takes memory operations from a processor core and hands them to a private cache one at a time, in the order the core supplied them. Only one access is outstanding at any moment. Each access is retired back to the core only after it is fully complete. A load is complete once the cache returns its block. A store is complete only once the coherence layer reports that its invalidation has been posted or acknowledged. The cache's own write acknowledgement does not retire a store.

While the head access waits, a prefetch walker moves through the queued operations and sends non-binding prefetch hints on a separate port. A store asks for the block with write intent, and a load asks for it readable. The hints only shorten later accesses. They never change which access goes to the cache next, and an entry that retires before its hint is sent is simply skipped.

Top module: `sc_mem_sequencer`

## Requirements
- R1: Cache requests are presented in exactly the order operations were accepted; a presented request keeps its address, kind and write data unchanged until `cache_req_ready` is sampled high.
- R2: After a request handshake, `cache_req_valid` stays low until that access completes, even when the next queued access would hit in the cache.
- R3: A load completes on the first cycle `cache_rsp_valid` is high while it waits; `coh_event_valid` during a load wait has no effect, and the load's `done_data` equals the `cache_rsp_data` sampled with that response.
- R4: A store completes only on a cycle with `coh_event_valid` high; a `cache_rsp_valid` pulse during a store wait neither retires it nor releases the next request.
- R5: `done_valid` is high for exactly one cycle, in the cycle after the completing event, with the access's tag, `done_is_store` (1 = store), and `done_data` (load data, or zero for a store); after reset it is low.
- R6: The queue holds DEPTH (default 8) operations; `req_ready` is high when fewer than DEPTH are held (including straight after reset) and low when DEPTH are held.
- R7: Prefetches go out in queue order, at most one per cycle, and are counted only on cycles with `pf_ready` high; `pf_excl` is 1 for a store (write-intent, modified state) and 0 for a load (shared or exclusive state); no entry is prefetched twice.
- R8: A load to the same address as the store just before it is not presented until that store completes, and its data comes from the cache response, never from the store's write data.
- R9: When an access completes and more operations are queued, the next request is presented in the cycle right after the completing event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers an operation |
| req_ready | output | 1 | Queue can accept an operation |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Store data |
| req_tag | input | TW | Core tag returned at completion |
| cache_req_valid | output | 1 | Access presented to the cache |
| cache_req_ready | input | 1 | Cache accepts the access |
| cache_req_is_store | output | 1 | Kind of presented access |
| cache_req_addr | output | AW | Address of presented access |
| cache_req_wdata | output | DW | Write data of presented access |
| cache_rsp_valid | input | 1 | Cache finished the outstanding access |
| cache_rsp_data | input | DW | Read data for a load |
| coh_event_valid | input | 1 | Invalidation posted or acknowledged for the outstanding store |
| pf_valid | output | 1 | Prefetch hint offered |
| pf_ready | input | 1 | Prefetch port accepts the hint |
| pf_addr | output | AW | Prefetch address |
| pf_excl | output | 1 | 1 = write intent, 0 = read intent |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TW | Tag of completed access |
| done_is_store | output | 1 | Kind of completed access |
| done_data | output | DW | Load data, zero for a store |

## Verification
Rounds of all loads, all stores, alternating kinds, and store-then-load pairs to one address are run with cache acceptance delays and response latencies that vary per access. Short and long latencies mimic hits behind misses and show that the order holds anyway. In each wait, the bench injects the event that must not retire the access (a coherence pulse for a load, a cache acknowledgement for a store), which separates completion by coherence from completion by cache response. The same-address pairs show that there is no forwarding. A prefetch port that is only ready two cycles in three shows that hints are ordered, typed and skipped rather than repeated.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  // Completion rule: loads finish on cache data, stores on coherence events.
  function automatic logic access_complete(input logic is_store,
                                           input logic rsp_seen,
                                           input logic coh_seen);
    return is_store ? coh_seen : rsp_seen;
  endfunction

  // Circular index: base plus offset, folded into [0, depth).
  function automatic int unsigned ring_index(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/sc_req_queue.sv
module sc_req_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int TW    = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_store,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_wdata,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          head_store,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_wdata,
  output logic [TW-1:0] head_tag,
  input  logic [CW-1:0] peek_off,
  output logic          peek_store,
  output logic [AW-1:0] peek_addr
);
  import sc_seq_pkg::*;

  logic          st_q   [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] wd_q   [DEPTH];
  logic [TW-1:0] tag_q  [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, peek_idx;
  logic [CW-1:0] cnt_q;

  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ring_index(int'(wr_ptr), 1, DEPTH));
      if (pop)  rd_ptr <= PW'(ring_index(int'(rd_ptr), 1, DEPTH));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      st_q[wr_ptr]   <= push_store;
      addr_q[wr_ptr] <= push_addr;
      wd_q[wr_ptr]   <= push_wdata;
      tag_q[wr_ptr]  <= push_tag;
    end
  end

  assign peek_idx   = PW'(ring_index(int'(rd_ptr), int'(peek_off), DEPTH));
  assign head_store = st_q[rd_ptr];
  assign head_addr  = addr_q[rd_ptr];
  assign head_wdata = wd_q[rd_ptr];
  assign head_tag   = tag_q[rd_ptr];
  assign peek_store = st_q[peek_idx];
  assign peek_addr  = addr_q[peek_idx];
endmodule

// File: rtl/sc_issue_ctrl.sv
module sc_issue_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic          head_store,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_wdata,
  input  logic [TW-1:0] head_tag,
  output logic          cache_req_valid,
  input  logic          cache_req_ready,
  output logic          cache_req_is_store,
  output logic [AW-1:0] cache_req_addr,
  output logic [DW-1:0] cache_req_wdata,
  input  logic          cache_rsp_valid,
  input  logic [DW-1:0] cache_rsp_data,
  input  logic          coh_event_valid,
  output logic          issue_evt,
  output logic          complete_evt,
  output logic          done_valid,
  output logic [TW-1:0] done_tag,
  output logic          done_is_store,
  output logic [DW-1:0] done_data
);
  import sc_seq_pkg::*;

  seq_state_e state_q;

  assign cache_req_valid    = (state_q == SEQ_IDLE) && head_valid;
  assign cache_req_is_store = head_store;
  assign cache_req_addr     = head_addr;
  assign cache_req_wdata    = head_wdata;

  assign issue_evt    = cache_req_valid && cache_req_ready;
  assign complete_evt = (state_q == SEQ_WAIT) &&
                        access_complete(head_store, cache_rsp_valid, coh_event_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= SEQ_IDLE;
      done_valid    <= 1'b0;
      done_tag      <= '0;
      done_is_store <= 1'b0;
      done_data     <= '0;
    end else begin
      done_valid <= complete_evt;
      if (issue_evt) state_q <= SEQ_WAIT;
      else if (complete_evt) state_q <= SEQ_IDLE;
      if (complete_evt) begin
        done_tag      <= head_tag;
        done_is_store <= head_store;
        done_data     <= head_store ? '0 : cache_rsp_data;
      end
    end
  end
endmodule

// File: rtl/sc_pf_walker.sv
module sc_pf_walker #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          pop,
  input  logic          peek_store,
  input  logic [AW-1:0] peek_addr,
  output logic [CW-1:0] peek_off,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr,
  output logic          pf_excl,
  output logic          pf_fire
);
  logic [CW-1:0] off_q, off_nxt;

  assign peek_off = off_q;
  assign pf_valid = off_q < count;
  assign pf_addr  = peek_addr;
  assign pf_excl  = peek_store;
  assign pf_fire  = pf_valid && pf_ready;

  always_comb begin
    off_nxt = off_q + CW'(pf_fire);
    if (pop && off_nxt != '0) off_nxt = off_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_nxt;
  end
endmodule

// File: rtl/sc_mem_sequencer.sv
module sc_mem_sequencer #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int TW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_is_store,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] req_tag,
  output logic          cache_req_valid,
  input  logic          cache_req_ready,
  output logic          cache_req_is_store,
  output logic [AW-1:0] cache_req_addr,
  output logic [DW-1:0] cache_req_wdata,
  input  logic          cache_rsp_valid,
  input  logic [DW-1:0] cache_rsp_data,
  input  logic          coh_event_valid,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr,
  output logic          pf_excl,
  output logic          done_valid,
  output logic [TW-1:0] done_tag,
  output logic          done_is_store,
  output logic [DW-1:0] done_data
);
  logic          q_full, q_empty;
  logic [CW-1:0] q_count, peek_off;
  logic          head_store, peek_store;
  logic [AW-1:0] head_addr, peek_addr;
  logic [DW-1:0] head_wdata;
  logic [TW-1:0] head_tag;
  logic          push_evt, issue_evt, complete_evt, pf_fire;

  assign req_ready = !q_full;
  assign push_evt  = req_valid && req_ready;

  sc_req_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push_evt), .push_store(req_is_store), .push_addr(req_addr),
    .push_wdata(req_wdata), .push_tag(req_tag),
    .pop(complete_evt), .full(q_full), .empty(q_empty), .count(q_count),
    .head_store(head_store), .head_addr(head_addr),
    .head_wdata(head_wdata), .head_tag(head_tag),
    .peek_off(peek_off), .peek_store(peek_store), .peek_addr(peek_addr)
  );

  sc_issue_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .head_valid(!q_empty), .head_store(head_store), .head_addr(head_addr),
    .head_wdata(head_wdata), .head_tag(head_tag),
    .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
    .cache_req_is_store(cache_req_is_store), .cache_req_addr(cache_req_addr),
    .cache_req_wdata(cache_req_wdata),
    .cache_rsp_valid(cache_rsp_valid), .cache_rsp_data(cache_rsp_data),
    .coh_event_valid(coh_event_valid),
    .issue_evt(issue_evt), .complete_evt(complete_evt),
    .done_valid(done_valid), .done_tag(done_tag),
    .done_is_store(done_is_store), .done_data(done_data)
  );

  sc_pf_walker #(.DEPTH(DEPTH), .AW(AW)) u_pf (
    .clk(clk), .rst_n(rst_n),
    .count(q_count), .pop(complete_evt),
    .peek_store(peek_store), .peek_addr(peek_addr), .peek_off(peek_off),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .pf_excl(pf_excl), .pf_fire(pf_fire)
  );
endmodule

// File: rtl/sc_seq_checker.sv
module sc_seq_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cache_req_valid,
  input logic          cache_req_ready,
  input logic          cache_req_is_store,
  input logic [AW-1:0] cache_req_addr,
  input logic          cache_rsp_valid,
  input logic          coh_event_valid,
  input logic          done_valid,
  input logic          done_is_store,
  input logic          pf_valid,
  input logic [CW-1:0] q_count,
  input logic          issue_evt,
  input logic          complete_evt
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (issue_evt) outstanding <= 1'b1;
    else if (complete_evt) outstanding <= 1'b0;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req_valid && !cache_req_ready |=> cache_req_valid && $stable(cache_req_addr) && $stable(cache_req_is_store)); // R1
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cache_req_valid); // R2
  AST_LOAD_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_is_store |-> $past(cache_rsp_valid)); // R3
  AST_STORE_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_is_store |-> $past(coh_event_valid)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH)); // R6
  AST_PF_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> q_count != '0); // R7
  AST_NEXT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    complete_evt && q_count > CW'(1) |=> cache_req_valid); // R9
endmodule

bind sc_mem_sequencer sc_seq_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
  .cache_req_is_store(cache_req_is_store), .cache_req_addr(cache_req_addr),
  .cache_rsp_valid(cache_rsp_valid), .coh_event_valid(coh_event_valid),
  .done_valid(done_valid), .done_is_store(done_is_store),
  .pf_valid(pf_valid), .q_count(q_count),
  .issue_evt(issue_evt), .complete_evt(complete_evt)
);

// File: tb/tb_sc_mem_sequencer.sv
module tb_sc_mem_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, AW = 8, DW = 16, TW = 4, NOPS = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_store = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic cache_req_ready = 0, cache_rsp_valid = 0, coh_event_valid = 0, pf_ready = 0;
  logic [DW-1:0] cache_rsp_data = '0;
  logic req_ready, cache_req_valid, cache_req_is_store, pf_valid, pf_excl;
  logic done_valid, done_is_store;
  logic [AW-1:0] cache_req_addr, pf_addr;
  logic [DW-1:0] cache_req_wdata, done_data;
  logic [TW-1:0] done_tag;

  int total = 0, bad = 0, pf_last = -1, cyc = 0;
  bit finished = 0;
  logic          op_st   [NOPS];
  logic [AW-1:0] op_addr [NOPS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_mem_sequencer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wdata_of(input int g);
    return DW'(g * 3 + 1);
  endfunction

  function automatic logic [DW-1:0] rdata_of(input int g);
    return {op_addr[g], 8'(g)} ^ 16'h5a00;
  endfunction

  // R7: prefetch monitor with a port ready two cycles in three
  always @(negedge clk) begin
    if (rst_n) begin
      if (pf_valid && pf_ready) begin : pf_chk
        int j;
        j = -1;
        for (int k = pf_last + 1; k < NOPS; k++)
          if (j < 0 && op_addr[k] == pf_addr && op_st[k] == pf_excl) j = k;
        chk(j >= 0, "R7 prefetch order/type", {pf_excl, 23'd0, pf_addr}, pf_last + 1);
        if (j >= 0) pf_last = j;
      end
      cyc++;
      pf_ready <= (cyc % 3) != 0;
    end
  end

  task automatic push_op(input int g);
    chk(req_ready == 1'b1, "R6 ready while not full", req_ready, 1);
    req_valid = 1; req_is_store = op_st[g]; req_addr = op_addr[g];
    req_wdata = wdata_of(g); req_tag = TW'(g);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic serve(input int g, input bit more);
    int w, rd, lat;
    string lbl;
    rd = g % 3; lat = (g * 5) % 4;
    lbl = (g + 1 < NOPS && !op_st[g+1] && op_st[g] && op_addr[g+1] == op_addr[g]) ? "R8 no early load" : "R2 one outstanding";
    w = 0;
    while (!cache_req_valid && w < 50) begin @(negedge clk); w++; end
    chk(cache_req_valid, "R1 request presented", cache_req_valid, 1);
    chk(cache_req_addr == op_addr[g] && cache_req_is_store == op_st[g], "R1 program order",
        {cache_req_is_store, cache_req_addr}, {op_st[g], op_addr[g]});
    if (op_st[g]) chk(cache_req_wdata == wdata_of(g), "R1 store data", cache_req_wdata, wdata_of(g));
    for (int i = 0; i < rd; i++) begin
      @(negedge clk);
      chk(cache_req_valid && cache_req_addr == op_addr[g], "R1 held until ready", cache_req_addr, op_addr[g]);
    end
    cache_req_ready = 1; @(negedge clk); cache_req_ready = 0;
    if (!op_st[g]) begin
      coh_event_valid = 1; @(negedge clk); coh_event_valid = 0;
      chk(!done_valid, "R3 coherence ignored on load", done_valid, 0);
      chk(!cache_req_valid, "R2 one outstanding", cache_req_valid, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(!done_valid && !cache_req_valid, "R2 hit waits behind miss", {done_valid, cache_req_valid}, 0);
      end
      cache_rsp_valid = 1; cache_rsp_data = rdata_of(g); @(negedge clk); cache_rsp_valid = 0;
      chk(done_valid, "R5 done after load", done_valid, 1);
      chk(done_data == rdata_of(g), (g > 0 && op_st[g-1] && op_addr[g-1] == op_addr[g]) ? "R8 data from cache" : "R3 load data",
          done_data, rdata_of(g));
      chk(!done_is_store, "R5 kind", done_is_store, 0);
    end else begin
      cache_rsp_valid = 1; cache_rsp_data = 16'hdead; @(negedge clk); cache_rsp_valid = 0;
      chk(!done_valid, "R4 cache ack alone", done_valid, 0);
      chk(!cache_req_valid, lbl, cache_req_valid, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(!done_valid && !cache_req_valid, lbl, {done_valid, cache_req_valid}, 0);
      end
      coh_event_valid = 1; @(negedge clk); coh_event_valid = 0;
      chk(done_valid && done_is_store, "R4 store done on coherence", {done_valid, done_is_store}, 3);
      chk(done_data == '0, "R5 store data zero", done_data, 0);
    end
    chk(done_tag == TW'(g), "R5 tag", done_tag, TW'(g));
    chk(cache_req_valid == more, "R9 next issue", cache_req_valid, more);
    @(negedge clk);
    chk(!done_valid, "R5 single pulse", done_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int g, n;
    int rlen [5] = '{8, 8, 8, 8, 5};
    for (int k = 0; k < NOPS; k++) begin
      op_addr[k] = AW'(8'h10 + k);
      op_st[k] = 0;
    end
    // rounds: loads, stores, alternating, store/load same-address pairs, mixed
    for (int k = 8; k < 16; k++) op_st[k] = 1;
    for (int k = 16; k < 24; k++) op_st[k] = k[0];
    for (int k = 24; k < 32; k++) begin
      op_st[k] = !k[0];
      if (k[0]) op_addr[k] = op_addr[k-1];
    end
    for (int k = 32; k < 37; k++) op_st[k] = (k % 3) == 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !cache_req_valid && !done_valid && !pf_valid, "R5 R6 reset state",
        {req_ready, cache_req_valid, done_valid, pf_valid}, 4'b1000);
    g = 0;
    for (int r = 0; r < 5; r++) begin
      n = rlen[r];
      for (int i = 0; i < n; i++) push_op(g + i);
      if (n == DEPTH) chk(!req_ready, "R6 full stalls intake", req_ready, 0);
      for (int i = 0; i < n; i++) serve(g + i, i < n - 1);
      g += n;
    end
    repeat (3) @(negedge clk);
    chk(pf_last >= 0, "R7 prefetches seen", pf_last, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule